// File: doc/BRIEF.md
# Sub-Addressed Register Slave on a Two-Wire Serial Bus

This block is an I2C target that holds a small file of 8-bit registers. A master reaches a register by writing its 8-bit index into a pointer, and then either writes data to that register or reads it back. Only the 7-bit device address 0x21 is answered. The bus wires are sampled through synchronizers that run on the system clock. The block drives SDA only by enabling an open-drain pull-down. It never stretches the clock.

A read is done in two steps. First a write transaction sets the pointer. Then a repeated START, or a STOP followed by a new START, opens a read transaction at the stored index. The pointer never advances by itself. A read of several bytes therefore returns the same register again and again, until the master answers a byte with NACK. Several data bytes written after one index byte all land in that same register.

Top module: `sreg_i2c_slave`

## Requirements
- R1: After reset the pull-down is off, every register holds 0x00 and the pointer is 0, so a read with no prior index write returns 0x00.
- R2: The slave ACKs the address byte 0x42 (device 0x21, write) and 0x43 (device 0x21, read). It ACKs by pulling SDA low during the ninth SCL pulse.
- R3: Any other address byte gets no ACK. The slave then keeps SDA released for the rest of that transaction, and no register or pointer changes.
- R4: In a write transaction, the index byte and every data byte are ACKed on their ninth SCL pulse.
- R5: Data bytes that follow the index byte go to the register the index selects. With several data bytes, the last one is what remains, and the next register is left unchanged.
- R6: After a repeated START with read address 0x43, the slave sends the register at the stored index, MSB first. The index survives a STOP.
- R7: While the master ACKs each read byte, the slave sends the same register value again.
- R8: After a master NACK the slave keeps SDA released until the next START or STOP. Bytes clocked after the NACK read as 0xFF.
- R9: A STOP ends the transaction in any state. A data byte cut short by a STOP is not written.
- R10: An index at or above the register count reads as 0x00, and writes to it are dropped. Both the index byte and the data byte are still ACKed.
- R11: The pull-down enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all bus sampling runs on it |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaPullDown | output | 1 | When high, the pad pulls SDA to ground |

## Verification
Most internal faults show up on SDA within one byte. A wrong pointer or a wrong register write appears as a bad data byte on the next read. A wrong address match appears as a missing or extra ACK on the ninth pulse of the address byte. A fault in the state sequence shows up in a few ways: SDA held low past a STOP, an ACK one pulse late, or an edge on SDA while SCL is high. The bench compares every ACK bit and every read byte against a queue of values derived from the requirements.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS) + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXEND,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_MACKEND,
    ST_IGNORE
  } ctlState_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } phase_t;

  // control -> datapath
  typedef struct packed {
    logic shiftRx;
    logic loadPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
    logic ackOn;
    logic txOn;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic                 sclRise;
    logic                 sclFall;
    logic                 startDet;
    logic                 stopDet;
    logic                 sdaBit;
    logic [BYTE_BITS-1:0] rxByte;
  } dpStatus_t;

endpackage

// File: rtl/sreg_datapath.sv
module sreg_datapath
  import sreg_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  ctlStrobe_t cs,
  output dpStatus_t  st,
  output logic       sdaPullDown
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  // synchronizers, idle-high
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  // receive and transmit shifters, pointer
  logic [BYTE_BITS-1:0] rxShift, txShift, ptr, rdData;
  logic [NUM_REGS-1:0][BYTE_BITS-1:0] regFile;
  logic inRange;

  assign inRange = int'(ptr) < NUM_REGS;
  assign rdData  = inRange ? regFile[ptr[IDX_W-1:0]] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      ptr     <= '0;
    end else begin
      if (cs.shiftRx) rxShift <= {rxShift[BYTE_BITS-2:0], sdaS};
      if (cs.loadPtr) ptr <= rxShift;
      if (cs.loadTx) txShift <= rdData;
      else if (cs.shiftTx) txShift <= {txShift[BYTE_BITS-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regFile <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (cs.writeReg && int'(ptr) == i) regFile[i] <= rxShift;
      end
    end
  end

  always_comb begin
    st.sclRise  = sclS & ~sclD;
    st.sclFall  = ~sclS & sclD;
    st.startDet = sclS & sclD & sdaD & ~sdaS;
    st.stopDet  = sclS & sclD & ~sdaD & sdaS;
    st.sdaBit   = sdaS;
    st.rxByte   = rxShift;
  end

  assign sdaPullDown = cs.ackOn | (cs.txOn & ~txShift[BYTE_BITS-1]);

endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h21
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  st,
  output ctlStrobe_t cs,
  output ctlState_t  stateOut
);

  ctlState_t        state, nState;
  phase_t           phase, nPhase;
  logic [CNT_W-1:0] bitCnt, nCnt;
  logic             rdMode, nRd, ackOn, nAck, txOn, nTx;

  always_comb begin
    nState = state;
    nPhase = phase;
    nCnt   = bitCnt;
    nRd    = rdMode;
    nAck   = ackOn;
    nTx    = txOn;
    cs     = '0;

    if (st.stopDet) begin
      nState = ST_IDLE;
      nAck   = 1'b0;
      nTx    = 1'b0;
    end else if (st.startDet) begin
      nState = ST_RX;
      nPhase = PH_ADDR;
      nCnt   = '0;
      nAck   = 1'b0;
      nTx    = 1'b0;
    end else begin
      unique case (state)
        ST_RX: if (st.sclRise) begin
          cs.shiftRx = 1'b1;
          nCnt       = CNT_W'(bitCnt + 1'b1);
          if (bitCnt == CNT_W'(BYTE_BITS - 1)) nState = ST_RXEND;
        end
        ST_RXEND: if (st.sclFall) begin
          unique case (phase)
            PH_ADDR: begin
              if (st.rxByte[7:1] == DEV_ADDR) begin
                nRd    = st.rxByte[0];
                nAck   = 1'b1;
                nState = ST_ACK;
              end else begin
                nState = ST_IGNORE;
              end
            end
            PH_SUB: begin
              cs.loadPtr = 1'b1;
              nAck       = 1'b1;
              nState     = ST_ACK;
            end
            default: begin
              cs.writeReg = 1'b1;
              nAck        = 1'b1;
              nState      = ST_ACK;
            end
          endcase
        end
        ST_ACK: if (st.sclFall) begin
          nAck = 1'b0;
          nCnt = '0;
          if (phase == PH_ADDR && rdMode) begin
            cs.loadTx = 1'b1;
            nTx       = 1'b1;
            nState    = ST_TX;
          end else begin
            nState = ST_RX;
            nPhase = (phase == PH_ADDR) ? PH_SUB : PH_DATA;
          end
        end
        ST_TX: begin
          if (st.sclRise) nCnt = CNT_W'(bitCnt + 1'b1);
          if (st.sclFall) begin
            if (bitCnt == CNT_W'(BYTE_BITS)) begin
              nTx    = 1'b0;
              nState = ST_MACK;
            end else begin
              cs.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: if (st.sclRise) begin
          nState = st.sdaBit ? ST_IGNORE : ST_MACKEND;
        end
        ST_MACKEND: if (st.sclFall) begin
          cs.loadTx = 1'b1;
          nTx       = 1'b1;
          nCnt      = '0;
          nState    = ST_TX;
        end
        default: ;
      endcase
    end

    cs.ackOn = ackOn;
    cs.txOn  = txOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= PH_ADDR;
      bitCnt <= '0;
      rdMode <= 1'b0;
      ackOn  <= 1'b0;
      txOn   <= 1'b0;
    end else begin
      state  <= nState;
      phase  <= nPhase;
      bitCnt <= nCnt;
      rdMode <= nRd;
      ackOn  <= nAck;
      txOn   <= nTx;
    end
  end

  assign stateOut = state;

endmodule

// File: rtl/sreg_i2c_slave.sv
module sreg_i2c_slave
  import sreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h21,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullDown
);

  ctlStrobe_t cs;
  dpStatus_t  dpStat;
  ctlState_t  ctlState;

  sreg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .st       (dpStat),
    .cs       (cs),
    .stateOut (ctlState)
  );

  sreg_datapath #(.NUM_REGS(NUM_REGS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .cs          (cs),
    .st          (dpStat),
    .sdaPullDown (sdaPullDown)
  );

endmodule

// File: rtl/sreg_i2c_slave_chk.sv
module sreg_i2c_slave_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaPullDown,
  input logic stopSeen,
  input logic fallSeen,
  input logic regWrite,
  input logic ptrLoad,
  input logic ignoring
);

  // R1
  released_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !sdaPullDown);

  // R11
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullDown) |-> !sclIn);

  // R9
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaPullDown);

  // R3
  ignore_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    ignoring |-> !sdaPullDown);

  // R4
  update_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite || ptrLoad) |-> fallSeen);

endmodule

bind sreg_i2c_slave sreg_i2c_slave_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sclIn       (sclIn),
  .sdaPullDown (sdaPullDown),
  .stopSeen    (dpStat.stopDet),
  .fallSeen    (dpStat.sclFall),
  .regWrite    (cs.writeReg),
  .ptrLoad     (cs.loadPtr),
  .ignoring    (ctlState == sreg_pkg::ST_IGNORE)
);

// File: tb/sreg_i2c_slave_test.sv
module sreg_i2c_slave_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaPullDown;
  logic sdaLine;
  assign sdaLine = mSda & ~sdaPullDown;

  sreg_i2c_slave uut (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (mScl),
    .sdaIn       (sdaLine),
    .sdaPullDown (sdaPullDown)
  );

  int checks = 0;
  int errors = 0;
  int highMoves = 0;
  logic prevPd = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } item_t;

  item_t      expQ[$];
  logic [7:0] gotQ[$];

  task automatic checkNow(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // monitor: pops observed results and compares them with queued expectations
  always @(negedge clk) begin
    while (gotQ.size() > 0) begin
      logic [7:0] g;
      item_t e;
      g = gotQ.pop_front();
      if (expQ.size() == 0) begin
        checkNow(g, 8'hxx, "unexpected result");
      end else begin
        e = expQ.pop_front();
        checkNow(g, e.val, e.tag);
      end
    end
  end

  // R11: the slave must not move SDA while SCL is high
  always @(posedge clk) begin
    prevPd <= sdaPullDown;
    if (rstN && (sdaPullDown !== prevPd) && mScl) highMoves++;
  end

  task automatic tq();
    repeat (10) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; tq();
    mScl = 1'b1; tq();
    mSda = 1'b0; tq();
    mScl = 1'b0; tq();
  endtask

  task automatic busStop();
    mSda = 1'b0; tq();
    mScl = 1'b1; tq();
    mSda = 1'b1; tq(); tq();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mSda = b[i]; tq();
      mScl = 1'b1; tq(); tq();
      mScl = 1'b0; tq();
    end
  endtask

  // driver: pushes the expected ACK bit (0 = ACK) then the observed one
  task automatic sendByte(input logic [7:0] b, input logic acked, input string tag);
    sendBits(b, 8);
    expQ.push_back('{val: {7'd0, ~acked}, tag: tag});
    mSda = 1'b1; tq();
    mScl = 1'b1; tq();
    gotQ.push_back({7'd0, sdaLine});
    tq();
    mScl = 1'b0; tq();
  endtask

  task automatic recvByte(input logic [7:0] expV, input logic nack, input string tag);
    logic [7:0] b;
    expQ.push_back('{val: expV, tag: tag});
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tq();
      mScl = 1'b1; tq();
      b[i] = sdaLine; tq();
      mScl = 1'b0;
    end
    gotQ.push_back(b);
    tq();
    mSda = nack; tq();
    mScl = 1'b1; tq(); tq();
    mScl = 1'b0; tq();
    mSda = 1'b1;
  endtask

  task automatic writeReg(input logic [7:0] idx, input logic [7:0] d, input string tag);
    busStart();
    sendByte(8'h42, 1'b1, tag);
    sendByte(idx, 1'b1, tag);
    sendByte(d, 1'b1, tag);
    busStop();
  endtask

  task automatic readReg(input logic [7:0] idx, input logic [7:0] expV, input string tag);
    busStart();
    sendByte(8'h42, 1'b1, tag);
    sendByte(idx, 1'b1, tag);
    busStart();
    sendByte(8'h43, 1'b1, tag);
    recvByte(expV, 1'b1, tag);
    busStop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    checkNow({7'd0, sdaPullDown}, 8'h00, "R1 pull-down off after reset");
    busStart();
    sendByte(8'h43, 1'b1, "R2 read address acked");
    recvByte(8'h00, 1'b1, "R1 reset register and pointer read zero");
    busStop();

    // R2 R4 R6 R7: write one register, read it back repeatedly
    busStart();
    sendByte(8'h42, 1'b1, "R2 write address acked");
    sendByte(8'h03, 1'b1, "R4 index byte acked");
    sendByte(8'hA5, 1'b1, "R4 data byte acked");
    busStop();
    busStart();
    sendByte(8'h42, 1'b1, "R2 write address acked");
    sendByte(8'h03, 1'b1, "R4 index byte acked");
    busStart();
    sendByte(8'h43, 1'b1, "R6 read after repeated start acked");
    recvByte(8'hA5, 1'b0, "R6 first read byte");
    recvByte(8'hA5, 1'b0, "R7 repeated read byte");
    recvByte(8'hA5, 1'b1, "R7 last read byte");
    busStop();

    // R5: several data bytes all land in one register
    busStart();
    sendByte(8'h42, 1'b1, "R2 write address acked");
    sendByte(8'h05, 1'b1, "R4 index byte acked");
    sendByte(8'h11, 1'b1, "R4 data byte acked");
    sendByte(8'h22, 1'b1, "R4 data byte acked");
    sendByte(8'h33, 1'b1, "R4 data byte acked");
    busStop();
    readReg(8'h05, 8'h33, "R5 last data byte kept");
    readReg(8'h06, 8'h00, "R5 next register untouched");

    // R6: pointer survives a STOP
    busStart();
    sendByte(8'h42, 1'b1, "R2 write address acked");
    sendByte(8'h03, 1'b1, "R4 index byte acked");
    busStop();
    busStart();
    sendByte(8'h43, 1'b1, "R2 read address acked");
    recvByte(8'hA5, 1'b1, "R6 pointer kept across stop");
    busStop();

    // R3: foreign addresses
    busStart();
    sendByte(8'h50, 1'b0, "R3 foreign write address not acked");
    sendByte(8'h03, 1'b0, "R3 later byte not acked");
    sendByte(8'h00, 1'b0, "R3 later byte not acked");
    busStop();
    busStart();
    sendByte(8'h45, 1'b0, "R3 foreign read address not acked");
    busStop();
    busStart();
    sendByte(8'h43, 1'b1, "R2 read address acked");
    recvByte(8'hA5, 1'b1, "R3 pointer and register unchanged");
    busStop();

    // R8: bus released after master NACK
    busStart();
    sendByte(8'h43, 1'b1, "R2 read address acked");
    recvByte(8'hA5, 1'b1, "R8 byte before nack");
    recvByte(8'hFF, 1'b1, "R8 released after nack");
    busStop();

    // R9: STOP mid data byte writes nothing
    busStart();
    sendByte(8'h42, 1'b1, "R2 write address acked");
    sendByte(8'h03, 1'b1, "R4 index byte acked");
    sendBits(8'h0F, 5);
    mScl = 1'b0;
    busStop();
    readReg(8'h03, 8'hA5, "R9 cut byte not written");

    // R10: index beyond the register file
    writeReg(8'h40, 8'h77, "R10 out-of-range write acked");
    readReg(8'h40, 8'h00, "R10 out-of-range read zero");
    readReg(8'h00, 8'h00, "R10 dropped write did not alias");

    repeat (20) @(negedge clk);
    checkNow(8'(expQ.size()), 8'h00, "pending expectations drained");
    checkNow(8'(highMoves), 8'h00, "R11 pull-down moved while SCL high");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule